// File: doc/BRIEF.md
# Bus-Kicked Watchdog Timer

This block is a watchdog timer that gets its restart from traffic on a shared two-wire I2C bus. It has no dedicated kick pin. It watches already-synchronized samples of the clock line (SCL) and the data line (SDA). A bus start condition arms it, and the next stop condition restarts the count. Software keeps the system alive by issuing any complete bus transaction before the selected period runs out. A hung processor, or a bus whose data line is stuck, lets the period expire. When the period expires, the block emits a one-cycle timeout pulse to the reset generator.

The timeout length comes from a two-bit period code held in a register inside the block. Three codes select a period, counted in 1 ms ticks supplied by the system. The fourth code turns the watchdog off. A write-protect level freezes the period code. The counter also restarts when the period code changes and while the system reset is active. As a result, a fresh full interval begins when reset is released.

Top module: `bus_watchdog`

## Requirements
- R1: The period code selects the number of ticks before a timeout: 2'b00 = TICKS_LONG (1400), 2'b01 = TICKS_MID (600), 2'b10 = TICKS_SHORT (200). With no restart, the timeout fires on exactly that tick and on no earlier one.
- R2: Period code 2'b11 disables the watchdog, and no timeout is ever produced while it is selected.
- R3: `timeout` is high for a single clock cycle. It is high in the cycle after the posedge that sampled the final tick. The count then starts again, so an unserviced watchdog fires once per period.
- R4: A start condition (SDA 1 to 0 while SCL stays 1) followed by a stop condition (SDA 0 to 1 while SCL stays 1) clears the tick count. A full period must then elapse before a timeout.
- R5: A start that is not followed by a stop does not restart the count. A stop that is not preceded by a start does not restart it either.
- R6: A second start before the stop keeps the watch armed, and the stop that follows restarts the count.
- R7: SDA changes while SCL is low are neither start nor stop conditions. A bus that is idle or stuck does not restart the count.
- R8: While `wr_protect` is 1, writes to the period code are ignored and `cfg_code` keeps its value. While it is 0, a write updates `cfg_code` one cycle later.
- R9: Writing a period code that differs from the current one restarts the count from zero.
- R10: While `sys_rst` is 1, the count is held at zero and no timeout is produced. A full period is needed after `sys_rst` is released.
- R11: After `rst_n` is asserted, `timeout` is 0 and the period code equals RESET_CODE (default 2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sys_rst | input | 1 | System reset level; holds the count at zero |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| scl_in | input | 1 | Synchronized SCL sample |
| sda_in | input | 1 | Synchronized SDA sample |
| wr_en | input | 1 | Period code write strobe |
| wr_code | input | 2 | Period code to write |
| wr_protect | input | 1 | 1 blocks period code writes |
| cfg_code | output | 2 | Current period code |
| timeout | output | 1 | One-cycle timeout pulse to the reset generator |

## Verification
The embedded properties watch several rules on every cycle:
- a start always arms the stop watch;
- a restart, a period code change, a system reset or the off code always leaves the count at zero with no pulse;
- the count never reaches the selected limit;
- write protect freezes the code;
- a pulse never lasts two cycles.

Other behaviour only the bench scenarios can show. These are the exact tick on which each period fires, and the repetition when the watchdog is left unserviced. They also include the cases where bus activity must not count as a restart: a lone start, a lone stop, and SDA toggling under a low SCL. Last, the bench confirms that a code change or a reset release buys a full new period.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_code_e;

    // Tick limit for a code; zero for the disabled code.
    function automatic int unsigned wd_limit(
        input wd_code_e    code,
        input int unsigned t_long,
        input int unsigned t_mid,
        input int unsigned t_short
    );
        case (code)
            WD_LONG:  return t_long;
            WD_MID:   return t_mid;
            WD_SHORT: return t_short;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/bwd_bus_monitor.sv
module bwd_bus_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic kick_o
);
    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic armed;
        logic kick;
    } mon_t;

    mon_t st_d, st_q;
    logic start_c, stop_c;

    always_comb begin
        st_d          = st_q;
        start_c       = st_q.scl_prev & scl_i & st_q.sda_prev & ~sda_i;
        stop_c        = st_q.scl_prev & scl_i & ~st_q.sda_prev & sda_i;
        st_d.scl_prev = scl_i;
        st_d.sda_prev = sda_i;
        st_d.kick     = stop_c & st_q.armed;
        if (start_c) begin
            st_d.armed = 1'b1;
        end else if (stop_c) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl_prev: 1'b1, sda_prev: 1'b1, armed: 1'b0, kick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign kick_o = st_q.kick;

    // R5/R6: a start always leaves the monitor armed
    a_r6_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> st_q.armed);

    // R5: a restart only follows a stop seen on the bus
    a_r5_kick_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.kick |-> ($past(scl_i) && $past(sda_i) && !$past(st_q.sda_prev)));

endmodule

// File: rtl/bwd_period_reg.sv
module bwd_period_reg
    import bwd_pkg::*;
#(
    parameter wd_code_e RESET_CODE = WD_LONG
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en_i,
    input  logic [1:0] wr_code_i,
    input  logic     wp_i,
    output wd_code_e code_o,
    output logic     chg_o
);
    typedef struct packed {
        wd_code_e code;
        logic     chg;
    } preg_t;

    preg_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (wr_en_i && !wp_i && (wd_code_e'(wr_code_i) != st_q.code)) begin
            st_d.code = wd_code_e'(wr_code_i);
            st_d.chg  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{code: RESET_CODE, chg: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign chg_o  = st_q.chg;

    // R8: protected code never moves
    a_r8_wp_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |=> $stable(st_q.code));

endmodule

// File: rtl/bwd_counter.sv
module bwd_counter
    import bwd_pkg::*;
#(
    parameter int unsigned TICKS_LONG  = 1400,
    parameter int unsigned TICKS_MID   = 600,
    parameter int unsigned TICKS_SHORT = 200
) (
    input  logic     clk,
    input  logic     rst_n,
    input  wd_code_e code_i,
    input  logic     chg_i,
    input  logic     kick_i,
    input  logic     sys_rst_i,
    input  logic     tick_i,
    output logic     fire_o
);
    localparam int unsigned MAX_A  = (TICKS_LONG > TICKS_MID) ? TICKS_LONG : TICKS_MID;
    localparam int unsigned MAX_T  = (MAX_A > TICKS_SHORT) ? MAX_A : TICKS_SHORT;
    localparam int          CNT_W  = $clog2(MAX_T + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } cnt_t;

    cnt_t             st_d, st_q;
    logic [CNT_W-1:0] limit_c;
    logic             restart_c;

    always_comb begin
        limit_c   = CNT_W'(wd_limit(code_i, TICKS_LONG, TICKS_MID, TICKS_SHORT));
        restart_c = sys_rst_i | kick_i | chg_i | (code_i == WD_OFF);
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (restart_c) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == limit_c - CNT_W'(1)) begin
                st_d.cnt  = '0;
                st_d.fire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, fire: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = st_q.fire;

    // R1: the count stays below the selected limit
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_i && code_i != WD_OFF) |-> (st_q.cnt < limit_c));

    // R2: disabled code produces no pulse
    a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == WD_OFF) |=> !st_q.fire);

    // R3: single-cycle pulse (limits above one tick per cycle)
    a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |=> !st_q.fire);

    // R4: a bus restart clears the count
    a_r4_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (st_q.cnt == '0 && !st_q.fire));

    // R9: a code change clears the count
    a_r9_chg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> (st_q.cnt == '0));

    // R10: system reset holds the count at zero
    a_r10_sysrst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_i |=> (st_q.cnt == '0 && !st_q.fire));

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import bwd_pkg::*;
#(
    parameter int unsigned TICKS_LONG  = 1400,
    parameter int unsigned TICKS_MID   = 600,
    parameter int unsigned TICKS_SHORT = 200,
    parameter logic [1:0]  RESET_CODE  = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_rst,
    input  logic       ms_tick,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       wr_en,
    input  logic [1:0] wr_code,
    input  logic       wr_protect,
    output logic [1:0] cfg_code,
    output logic       timeout
);
    wd_code_e code_w;
    logic     chg_w;
    logic     kick_w;

    bwd_bus_monitor u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_in),
        .sda_i  (sda_in),
        .kick_o (kick_w)
    );

    bwd_period_reg #(
        .RESET_CODE (wd_code_e'(RESET_CODE))
    ) u_preg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_code_i (wr_code),
        .wp_i      (wr_protect),
        .code_o    (code_w),
        .chg_o     (chg_w)
    );

    bwd_counter #(
        .TICKS_LONG  (TICKS_LONG),
        .TICKS_MID   (TICKS_MID),
        .TICKS_SHORT (TICKS_SHORT)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_i    (code_w),
        .chg_i     (chg_w),
        .kick_i    (kick_w),
        .sys_rst_i (sys_rst),
        .tick_i    (ms_tick),
        .fire_o    (timeout)
    );

    assign cfg_code = code_w;

endmodule

// File: tb/bus_watchdog_bench.sv
module bus_watchdog_bench;
    localparam int LONG_T  = 40;
    localparam int MID_T   = 20;
    localparam int SHORT_T = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_rst = 1'b0;
    logic       ms_tick = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_code = 2'b00;
    logic       wr_protect = 1'b0;
    logic [1:0] cfg_code;
    logic       timeout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_watchdog #(
        .TICKS_LONG  (LONG_T),
        .TICKS_MID   (MID_T),
        .TICKS_SHORT (SHORT_T),
        .RESET_CODE  (2'b00)
    ) u_bus_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_rst    (sys_rst),
        .ms_tick    (ms_tick),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .wr_en      (wr_en),
        .wr_code    (wr_code),
        .wr_protect (wr_protect),
        .cfg_code   (cfg_code),
        .timeout    (timeout)
    );

    // code, ticks applied after a restart, expected pulses
    localparam int VEC [7][3] = '{
        '{0, LONG_T,      1},
        '{0, LONG_T - 1,  0},
        '{1, MID_T,       1},
        '{1, MID_T - 1,   0},
        '{2, SHORT_T,     1},
        '{2, SHORT_T - 1, 0},
        '{3, 100,         0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus(input logic c, input logic d);
        @(negedge clk);
        scl_in = c;
        sda_in = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // start, data low, stop, then one idle cycle for the restart to land
    task automatic kick();
        bus(1, 0); bus(0, 0); bus(1, 0); bus(1, 1);
        idle(2);
    endtask

    task automatic ticks(input int n, output int fires);
        fires = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            if (timeout) fires++;
        end
    endtask

    task automatic write_code(input logic [1:0] c);
        @(negedge clk);
        wr_en = 1'b1;
        wr_code = c;
        @(negedge clk);
        wr_en = 1'b0;
        idle(1);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int f;
        idle(3);
        chk("R11 timeout in reset", int'(timeout), 0);
        chk("R11 code in reset", int'(cfg_code), 0);
        rst_n = 1'b1;
        idle(2);
        chk("R11 code after reset", int'(cfg_code), 0);

        // R1 R2 R4 R7: table walk
        foreach (VEC[k]) begin
            write_code(2'(VEC[k][0]));
            kick();
            ticks(VEC[k][1], f);
            chk($sformatf("R1/R2/R4 vector %0d", k), f, VEC[k][2]);
        end

        // R8: protected write ignored, unprotected write applied
        wr_protect = 1'b1;
        write_code(2'b10);
        chk("R8 protected write ignored", int'(cfg_code), 3);
        wr_protect = 1'b0;
        write_code(2'b10);
        chk("R8 open write applied", int'(cfg_code), 2);

        // R3: repeats each period, single-cycle pulse
        kick();
        ticks(2 * SHORT_T, f);
        chk("R3 two periods two pulses", f, 2);
        kick();
        ticks(SHORT_T, f);
        chk("R3 pulse on final tick", int'(timeout), 1);
        @(negedge clk);
        chk("R3 pulse one cycle", int'(timeout), 0);

        // R5: stop without start
        kick();
        ticks(SHORT_T - 2, f);
        bus(0, 1); bus(0, 0); bus(1, 0); bus(1, 1); idle(2);
        ticks(2, f);
        chk("R5 lone stop no restart", f, 1);

        // R5: start without stop
        kick();
        ticks(SHORT_T - 2, f);
        bus(1, 0); bus(0, 0); idle(2);
        ticks(2, f);
        chk("R5 lone start no restart", f, 1);
        bus(0, 1); bus(1, 1); idle(1);

        // R6: repeated start then stop restarts
        kick();
        ticks(SHORT_T - 2, f);
        bus(1, 0); bus(0, 0); bus(0, 1); bus(1, 1);
        bus(1, 0); bus(0, 0); bus(1, 0); bus(1, 1); idle(2);
        ticks(SHORT_T - 1, f);
        chk("R6 no pulse before full period", f, 0);
        ticks(1, f);
        chk("R6 pulse after full period", f, 1);

        // R7: SDA toggles under low SCL are ignored
        kick();
        ticks(SHORT_T - 2, f);
        bus(0, 1); bus(0, 0); bus(0, 1); bus(0, 0); bus(0, 1); bus(1, 1); idle(2);
        ticks(2, f);
        chk("R7 low-SCL toggles no restart", f, 1);

        // R9: code change restarts
        kick();
        ticks(SHORT_T - 2, f);
        write_code(2'b01);
        ticks(MID_T - 1, f);
        chk("R9 no pulse before new period", f, 0);
        ticks(1, f);
        chk("R9 pulse at new period", f, 1);

        // R10: system reset holds and restarts
        kick();
        ticks(MID_T - 5, f);
        @(negedge clk);
        sys_rst = 1'b1;
        ticks(3 * MID_T, f);
        chk("R10 no pulse under sys_rst", f, 0);
        @(negedge clk);
        sys_rst = 1'b0;
        idle(1);
        ticks(MID_T - 1, f);
        chk("R10 full period after release", f, 0);
        ticks(1, f);
        chk("R10 pulse after release period", f, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule